// File: doc/BRIEF.md
# PLL Reprogramming Sequencer

This block is the hardware owner of a PLL's three control words. It turns high-level commands into an ordered series of register changes: a rate command carrying new M, P, S and K values, a power-up command and a power-down command. The PLL watches three registers. The general control word holds the reset-release, bypass, lock-source select and clock-enable bits, and shows lock status in bit 31. The divider word holds M, P and S. The fractional word holds K.

A rate command whose M and P match the values already in place only rewrites the post-divider S, and K when fractional mode is built in. Any other rate command runs the protected sequence. The PLL is put in reset and bypassed. The dividers are written and a settling delay is counted. Reset is then released, the sequencer waits for lock, and bypass is removed. Delays are counted in whole microseconds derived from the clock-frequency parameter. A lock that does not arrive within the timeout ends the command with an error and leaves the PLL bypassed.

Top module: `pll_reprog_seq`

## Requirements
- R1: After reset the general control word reads 0x00000800: only clock enable (bit 11) is set. The divider and fractional words read 0. busy, done and err are low.
- R2: A rate command whose M and P equal the current divider values takes the short path. It rewrites S, and K when FRAC_EN=1. It leaves the general control word unchanged, and done is high in the second cycle after the command cycle.
- R3: A rate command that changes M or P applies its changes in this order: reset asserted (bit 9 cleared), bypass set (bit 4), divider word written, reset released, bypass cleared. The divider word is laid out as M in bits 21:12, P in bits 9:4 and S in bits 2:0.
- R4: Reset is released no sooner than SETTLE_US microseconds after the divider write, and no more than two cycles later.
- R5: Bypass is cleared only after the synchronised lock has been seen while reset is released.
- R6: If lock is not seen within LOCK_TMO_US microseconds of reset release, err pulses for one cycle. done stays low, and bypass and reset release stay set.
- R7: A power-up command while reset is already released completes with done in the next cycle and changes no register.
- R8: A power-up command from powered-down state sets bypass, then releases reset, then waits for lock, then clears bypass.
- R9: A power-down command clears the reset-release bit and then raises done.
- R10: busy is high from the cycle after acceptance until the done or err cycle, inclusive. Commands that arrive while busy is high are ignored.
- R11: When commands arrive in the same cycle, a rate command wins over power-up, and power-up wins over power-down.
- R12: Bit 31 of the general control word follows the lock input through a SYNC_STAGES-flop synchroniser.
- R13: The full path writes K into bits 15:0 of the fractional word when FRAC_EN=1. With FRAC_EN=0 the fractional word is never written, and lock-source select (bit 29) is set before reset is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rate_req | input | 1 | Rate command strobe |
| rate_m | input | 10 | Requested feedback divider M |
| rate_p | input | 6 | Requested pre-divider P |
| rate_s | input | 3 | Requested post-divider S |
| rate_k | input | 16 | Requested fractional value K |
| prep_req | input | 1 | Power-up command strobe |
| unprep_req | input | 1 | Power-down command strobe |
| pll_lock | input | 1 | Lock indication from the PLL (asynchronous) |
| gen_ctl | output | 32 | General control word |
| div_ctl | output | 32 | Divider word |
| frac_ctl | output | 32 | Fractional word |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle lock-timeout pulse |

## Verification
Two cases can fall in the same cycle. One is a collision between commands at acceptance. The other is a command arriving while a sequence is still running. The bench raises a rate command together with a power-down command, and a power-up together with a power-down. It judges the winner by the completion latency and by the reset-release bit left behind. It also pulses power-down one cycle after a full rate change has been accepted. It then confirms that reset release is still set once done fires and that busy drops in the following cycle.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;

  localparam int M_W = 10;
  localparam int P_W = 6;
  localparam int S_W = 3;
  localparam int K_W = 16;

  localparam int M_LSB     = 12;
  localparam int P_LSB     = 4;
  localparam int S_LSB     = 0;
  localparam int K_LSB     = 0;
  localparam int LOCK_BIT  = 31;
  localparam int LSEL_BIT  = 29;
  localparam int CLKEN_BIT = 11;
  localparam int RSTB_BIT  = 9;
  localparam int BYP_BIT   = 4;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_FAST,
    ST_LSEL,
    ST_RST_ON,
    ST_BYP_ON,
    ST_DIV_WR,
    ST_SETTLE,
    ST_RST_OFF,
    ST_LOCK,
    ST_BYP_OFF,
    ST_PBYP,
    ST_PREL,
    ST_UNPREP,
    ST_DONE,
    ST_ERR
  } seq_state_e;

  typedef struct packed {
    logic set_lsel;
    logic clr_rst;
    logic set_rst;
    logic set_byp;
    logic clr_byp;
    logic wr_div;
    logic wr_s;
    logic wr_k;
  } reg_act_t;

endpackage

// File: rtl/us_tick_gen.sv
module us_tick_gen #(
  parameter int CYC_PER_US = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic tick
);
  localparam int CNT_W = (CYC_PER_US > 1) ? $clog2(CYC_PER_US) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CYC_PER_US - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    if (clr) begin
      cnt_d = '0;
    end else if (cnt_q == LAST) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign tick = (cnt_q == LAST) && !clr;

endmodule

// File: rtl/lock_sync.sv
module lock_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] sh_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sh_q <= '0;
        end else begin
          sh_q <= din;
        end
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sh_q <= '0;
        end else begin
          sh_q <= {sh_q[STAGES-2:0], din};
        end
      end
    end
  endgenerate

  assign dout = sh_q[STAGES-1];

endmodule

// File: rtl/pll_seq_ctrl.sv
module pll_seq_ctrl
  import pll_seq_pkg::*;
#(
  parameter int SETTLE_US   = 3,
  parameter int LOCK_TMO_US = 10000,
  parameter bit FRAC_EN     = 1'b1
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     rate_req,
  input  logic     prep_req,
  input  logic     unprep_req,
  input  logic     mp_same,
  input  logic     rstb_now,
  input  logic     lock_s,
  input  logic     us_tick,
  output reg_act_t act,
  output logic     tick_clr,
  output logic     accept,
  output logic     busy,
  output logic     done,
  output logic     err
);
  localparam int MAX_US = (SETTLE_US > LOCK_TMO_US) ? SETTLE_US : LOCK_TMO_US;
  localparam int US_W   = $clog2(MAX_US + 1);
  localparam logic [US_W-1:0] SETTLE_LAST = US_W'(SETTLE_US - 1);
  localparam logic [US_W-1:0] TMO_LAST    = US_W'(LOCK_TMO_US - 1);

  seq_state_e      st_q, st_d;
  logic [US_W-1:0] us_q, us_d;

  always_comb begin
    st_d     = st_q;
    act      = '0;
    tick_clr = 1'b0;
    accept   = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (rate_req) begin
          accept = 1'b1;
          if (mp_same) begin
            st_d = ST_FAST;
          end else if (FRAC_EN) begin
            st_d = ST_RST_ON;
          end else begin
            st_d = ST_LSEL;
          end
        end else if (prep_req) begin
          st_d = rstb_now ? ST_DONE : ST_PBYP;
        end else if (unprep_req) begin
          st_d = ST_UNPREP;
        end
      end
      ST_FAST: begin
        act.wr_s = 1'b1;
        act.wr_k = FRAC_EN;
        st_d     = ST_DONE;
      end
      ST_LSEL: begin
        act.set_lsel = 1'b1;
        st_d         = ST_RST_ON;
      end
      ST_RST_ON: begin
        act.clr_rst = 1'b1;
        st_d        = ST_BYP_ON;
      end
      ST_BYP_ON: begin
        act.set_byp = 1'b1;
        st_d        = ST_DIV_WR;
      end
      ST_DIV_WR: begin
        act.wr_div = 1'b1;
        act.wr_k   = FRAC_EN;
        tick_clr   = 1'b1;
        st_d       = ST_SETTLE;
      end
      ST_SETTLE: begin
        if (us_tick && (us_q == SETTLE_LAST)) begin
          st_d = ST_RST_OFF;
        end
      end
      ST_RST_OFF: begin
        act.set_rst = 1'b1;
        tick_clr    = 1'b1;
        st_d        = ST_LOCK;
      end
      ST_LOCK: begin
        if (lock_s) begin
          st_d = ST_BYP_OFF;
        end else if (us_tick && (us_q == TMO_LAST)) begin
          st_d = ST_ERR;
        end
      end
      ST_BYP_OFF: begin
        act.clr_byp = 1'b1;
        st_d        = ST_DONE;
      end
      ST_PBYP: begin
        act.set_byp = 1'b1;
        st_d        = ST_PREL;
      end
      ST_PREL: begin
        act.set_rst = 1'b1;
        tick_clr    = 1'b1;
        st_d        = ST_LOCK;
      end
      ST_UNPREP: begin
        act.clr_rst = 1'b1;
        st_d        = ST_DONE;
      end
      ST_DONE: st_d = ST_IDLE;
      ST_ERR:  st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_comb begin
    if (tick_clr) begin
      us_d = '0;
    end else if (us_tick) begin
      us_d = us_q + 1'b1;
    end else begin
      us_d = us_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
      us_q <= '0;
    end else begin
      st_q <= st_d;
      us_q <= us_d;
    end
  end

  assign busy = (st_q != ST_IDLE);
  assign done = (st_q == ST_DONE);
  assign err  = (st_q == ST_ERR);

endmodule

// File: rtl/pll_reprog_seq.sv
module pll_reprog_seq
  import pll_seq_pkg::*;
#(
  parameter int CLK_FREQ_HZ = 200_000_000,
  parameter int SETTLE_US   = 3,
  parameter int LOCK_TMO_US = 10000,
  parameter bit FRAC_EN     = 1'b1,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rate_req,
  input  logic [9:0]  rate_m,
  input  logic [5:0]  rate_p,
  input  logic [2:0]  rate_s,
  input  logic [15:0] rate_k,
  input  logic        prep_req,
  input  logic        unprep_req,
  input  logic        pll_lock,
  output logic [31:0] gen_ctl,
  output logic [31:0] div_ctl,
  output logic [31:0] frac_ctl,
  output logic        busy,
  output logic        done,
  output logic        err
);
  localparam int CYC_RAW    = CLK_FREQ_HZ / 1_000_000;
  localparam int CYC_PER_US = (CYC_RAW > 0) ? CYC_RAW : 1;

  logic [M_W-1:0] m_q, pend_m;
  logic [P_W-1:0] p_q, pend_p;
  logic [S_W-1:0] s_q, pend_s;
  logic [K_W-1:0] k_q, pend_k;
  logic           lsel_q, rstb_q, byp_q;

  logic     lock_s;
  logic     us_tick;
  logic     tick_clr;
  logic     accept;
  logic     mp_same;
  reg_act_t act;

  lock_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (pll_lock),
    .dout (lock_s)
  );

  us_tick_gen #(.CYC_PER_US(CYC_PER_US)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (tick_clr),
    .tick (us_tick)
  );

  assign mp_same = (rate_m == m_q) && (rate_p == p_q);

  pll_seq_ctrl #(
    .SETTLE_US  (SETTLE_US),
    .LOCK_TMO_US(LOCK_TMO_US),
    .FRAC_EN    (FRAC_EN)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .rate_req  (rate_req),
    .prep_req  (prep_req),
    .unprep_req(unprep_req),
    .mp_same   (mp_same),
    .rstb_now  (rstb_q),
    .lock_s    (lock_s),
    .us_tick   (us_tick),
    .act       (act),
    .tick_clr  (tick_clr),
    .accept    (accept),
    .busy      (busy),
    .done      (done),
    .err       (err)
  );

  // pending command, captured on acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_m <= '0;
      pend_p <= '0;
      pend_s <= '0;
      pend_k <= '0;
    end else if (accept) begin
      pend_m <= rate_m;
      pend_p <= rate_p;
      pend_s <= rate_s;
      pend_k <= rate_k;
    end
  end

  // general control bits
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lsel_q <= 1'b0;
      rstb_q <= 1'b0;
      byp_q  <= 1'b0;
    end else begin
      if (act.set_lsel) lsel_q <= 1'b1;
      if (act.clr_rst) begin
        rstb_q <= 1'b0;
      end else if (act.set_rst) begin
        rstb_q <= 1'b1;
      end
      if (act.set_byp) begin
        byp_q <= 1'b1;
      end else if (act.clr_byp) begin
        byp_q <= 1'b0;
      end
    end
  end

  // divider fields
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_q <= '0;
      p_q <= '0;
      s_q <= '0;
    end else begin
      if (act.wr_div) begin
        m_q <= pend_m;
        p_q <= pend_p;
      end
      if (act.wr_div || act.wr_s) s_q <= pend_s;
    end
  end

  // fractional field: present only when built in
  generate
    if (FRAC_EN) begin : g_frac
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          k_q <= '0;
        end else if (act.wr_k) begin
          k_q <= pend_k;
        end
      end
    end else begin : g_nofrac
      assign k_q = '0;
    end
  endgenerate

  always_comb begin
    gen_ctl            = '0;
    gen_ctl[LOCK_BIT]  = lock_s;
    gen_ctl[LSEL_BIT]  = lsel_q;
    gen_ctl[CLKEN_BIT] = 1'b1;
    gen_ctl[RSTB_BIT]  = rstb_q;
    gen_ctl[BYP_BIT]   = byp_q;

    div_ctl                    = '0;
    div_ctl[M_LSB +: M_W]      = m_q;
    div_ctl[P_LSB +: P_W]      = p_q;
    div_ctl[S_LSB +: S_W]      = s_q;

    frac_ctl                   = '0;
    frac_ctl[K_LSB +: K_W]     = k_q;
  end

endmodule

// File: rtl/pll_seq_chk.sv
module pll_seq_chk #(
  parameter bit FRAC_EN = 1'b1
) (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] gen_ctl,
  input logic [31:0] div_ctl,
  input logic        busy,
  input logic        done,
  input logic        err
);

  p_rst_release_bypassed_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gen_ctl[9]) |-> gen_ctl[4]);

  // R13: in integer mode lock-source select is already set
  p_div_change_in_reset_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(div_ctl[21:4]) |-> (!gen_ctl[9] && gen_ctl[4] && (FRAC_EN || gen_ctl[29])));

  p_bypass_clear_after_lock_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(gen_ctl[4]) |-> $past(gen_ctl[31]));

  p_err_holds_bypass_r6: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (gen_ctl[4] && gen_ctl[9]));

  p_busy_ends_on_result_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(done || err));

  p_result_single_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (done || err) |=> !(done || err));

endmodule

bind pll_reprog_seq pll_seq_chk #(.FRAC_EN(FRAC_EN)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .gen_ctl(gen_ctl),
  .div_ctl(div_ctl),
  .busy   (busy),
  .done   (done),
  .err    (err)
);

// File: tb/tb_pll_reprog_seq.sv
`timescale 1ns/1ps
module tb_pll_reprog_seq;
  localparam int FREQ = 4_000_000;
  localparam int CYC  = 4;
  localparam int SET  = 3;
  localparam int TMO  = 25;
  localparam int LDLY = 10;

  logic clk, rst_n;
  logic rate_req, prep_req, unprep_req;
  logic [9:0] rate_m;
  logic [5:0] rate_p;
  logic [2:0] rate_s;
  logic [15:0] rate_k;
  logic lock1, lock0, lock_never;
  logic [31:0] g1, d1, f1, g0, d0, f0;
  logic busy1, done1, err1, busy0, done0, err0;
  int c1, c0;
  int checks, errors;

  int t_rf, t_br, t_dv, t_rr, t_bf, t_li, t_rfi, n_cyc;
  bit lock_at_bf, saw_done, saw_err;

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  pll_reprog_seq #(.CLK_FREQ_HZ(FREQ), .SETTLE_US(SET), .LOCK_TMO_US(TMO),
                   .FRAC_EN(1'b1), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst_n(rst_n), .rate_req(rate_req), .rate_m(rate_m), .rate_p(rate_p),
    .rate_s(rate_s), .rate_k(rate_k), .prep_req(prep_req), .unprep_req(unprep_req),
    .pll_lock(lock1), .gen_ctl(g1), .div_ctl(d1), .frac_ctl(f1),
    .busy(busy1), .done(done1), .err(err1));

  pll_reprog_seq #(.CLK_FREQ_HZ(FREQ), .SETTLE_US(SET), .LOCK_TMO_US(TMO),
                   .FRAC_EN(1'b0), .SYNC_STAGES(2)) dut_int (
    .clk(clk), .rst_n(rst_n), .rate_req(rate_req), .rate_m(rate_m), .rate_p(rate_p),
    .rate_s(rate_s), .rate_k(rate_k), .prep_req(prep_req), .unprep_req(unprep_req),
    .pll_lock(lock0), .gen_ctl(g0), .div_ctl(d0), .frac_ctl(f0),
    .busy(busy0), .done(done0), .err(err0));

  // PLL models: lock LDLY cycles after reset release
  always @(posedge clk) begin
    if (!rst_n || !g1[9]) c1 <= 0; else if (c1 < 1000) c1 <= c1 + 1;
    if (!rst_n || !g0[9]) c0 <= 0; else if (c0 < 1000) c0 <= c0 + 1;
  end
  assign lock1 = !lock_never && (c1 >= LDLY);
  assign lock0 = !lock_never && (c0 >= LDLY);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] div_word(input logic [9:0] m, input logic [5:0] p, input logic [2:0] s);
    return (32'(m) << 12) | (32'(p) << 4) | 32'(s);
  endfunction

  task automatic cmd(input bit r, input bit pr, input bit up, input logic [9:0] m,
                     input logic [5:0] p, input logic [2:0] s, input logic [15:0] k, input int limit);
    logic [31:0] pg, pd, pgi;
    pg = g1; pd = d1; pgi = g0;
    t_rf = -1; t_br = -1; t_dv = -1; t_rr = -1; t_bf = -1; t_li = -1; t_rfi = -1;
    lock_at_bf = 1'b0;
    rate_req = r; prep_req = pr; unprep_req = up;
    rate_m = m; rate_p = p; rate_s = s; rate_k = k;
    n_cyc = 0;
    do begin
      @(negedge clk);
      n_cyc++;
      rate_req = 1'b0; prep_req = 1'b0; unprep_req = 1'b0;
      if (pg[9] && !g1[9] && t_rf < 0) t_rf = n_cyc;
      if (!pg[4] && g1[4] && t_br < 0) t_br = n_cyc;
      if (pd != d1 && t_dv < 0) t_dv = n_cyc;
      if (!pg[9] && g1[9] && t_rr < 0) t_rr = n_cyc;
      if (pg[4] && !g1[4] && t_bf < 0) begin t_bf = n_cyc; lock_at_bf = g1[31]; end
      if (!pgi[29] && g0[29] && t_li < 0) t_li = n_cyc;
      if (pgi[9] && !g0[9] && t_rfi < 0) t_rfi = n_cyc;
      pg = g1; pd = d1; pgi = g0;
    end while (!(done1 || err1) && n_cyc < limit);
    saw_done = done1; saw_err = err1;
    repeat (8) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R10 watchdog actual=%0d expected=%0d", 200000, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [9:0] lm;
    logic [5:0] lp;
    int tb_n;
    checks = 0; errors = 0;
    rst_n = 1'b0; lock_never = 1'b0;
    rate_req = 0; prep_req = 0; unprep_req = 0;
    rate_m = 0; rate_p = 0; rate_s = 0; rate_k = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(g1 == 32'h0000_0800, "R1 gen_ctl", g1, 32'h800);
    chk(d1 == 0 && f1 == 0, "R1 div/frac", d1 | f1, 0);
    chk({busy1, done1, err1} == 3'b000, "R1 status", {busy1, done1, err1}, 0);
    chk(g0 == 32'h0000_0800, "R1 int gen_ctl", g0, 32'h800);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R8 power-up from down
    cmd(0, 1, 0, 0, 0, 0, 0, 300);
    chk(saw_done && t_br > 0 && t_br < t_rr && t_rr < t_bf, "R8 order", t_bf, t_rr);
    chk(g1 == 32'h8000_0A00, "R8/R12 gen_ctl", g1, 32'h8000_0A00);
    chk(lock_at_bf, "R5 lock before bypass clear", lock_at_bf, 1);

    // R7 power-up when up
    cmd(0, 1, 0, 0, 0, 0, 0, 50);
    chk(n_cyc == 1 && saw_done, "R7 latency", n_cyc, 1);
    chk(g1 == 32'h8000_0A00, "R7 unchanged", g1, 32'h8000_0A00);

    // R3/R4/R5/R13 full path sweep
    for (int i = 0; i < 4; i++) begin
      logic [9:0] m; logic [5:0] p; logic [2:0] s; logic [15:0] k;
      m = 10'(100 + i * 37); p = 6'(2 + i); s = 3'(i); k = 16'(16'h1000 * i + 5);
      cmd(1, 0, 0, m, p, s, k, 500);
      chk(saw_done && t_rf > 0 && t_rf < t_br && t_br < t_dv && t_dv < t_rr && t_rr < t_bf,
          "R3 order", t_dv, t_br);
      chk(t_rr - t_dv >= SET * CYC && t_rr - t_dv <= SET * CYC + 2, "R4 settle",
          t_rr - t_dv, SET * CYC);
      chk(lock_at_bf && (t_bf - t_rr) >= LDLY, "R5 lock wait", t_bf - t_rr, LDLY);
      chk(d1 == div_word(m, p, s), "R3 div word", d1, div_word(m, p, s));
      chk(f1 == 32'(k), "R13 frac word", f1, 32'(k));
      chk(g1 == 32'h8000_0A00, "R3 gen_ctl final", g1, 32'h8000_0A00);
      chk(g0 == 32'hA000_0A00 && d0 == d1 && f0 == 0, "R13 integer mode", g0, 32'hA000_0A00);
      if (i == 0) chk(t_li > 0 && t_li < t_rfi, "R13 lsel before reset", t_li, t_rfi);
      lm = m; lp = p;
    end

    // R2 fast path over all S values
    for (int s = 0; s < 8; s++) begin
      logic [15:0] k;
      k = 16'(s * 1111 + 7);
      cmd(1, 0, 0, lm, lp, 3'(s), k, 50);
      chk(n_cyc == 2 && saw_done, "R2 latency", n_cyc, 2);
      chk(d1 == div_word(lm, lp, 3'(s)) && f1 == 32'(k), "R2 s/k", d1, div_word(lm, lp, 3'(s)));
      chk(t_rf < 0 && t_br < 0 && g1 == 32'h8000_0A00, "R2 control untouched", g1, 32'h8000_0A00);
      chk(d0 == d1 && f0 == 0, "R2 integer s only", d0, d1);
    end

    // R10 command during busy is ignored
    rate_req = 1; rate_m = 10'd300; rate_p = 6'd7; rate_s = 3'd1; rate_k = 16'd9;
    @(negedge clk);
    rate_req = 0;
    chk(busy1, "R10 busy after accept", busy1, 1);
    unprep_req = 1;
    @(negedge clk);
    unprep_req = 0;
    tb_n = 0;
    while (!done1 && tb_n < 500) begin @(negedge clk); tb_n++; end
    chk(done1 && busy1, "R10 busy in done cycle", {done1, busy1}, 2'b11);
    @(negedge clk);
    chk(!busy1 && g1[9], "R10 power-down ignored", g1, 32'h8000_0A00);
    repeat (8) @(negedge clk);
    lm = 10'd300; lp = 6'd7;

    // R11 same-cycle commands
    cmd(1, 0, 1, lm, lp, 3'd5, 16'd44, 50);
    chk(n_cyc == 2 && g1[9] && d1[2:0] == 3'd5, "R11 rate over power-down", d1, div_word(lm, lp, 5));
    cmd(0, 1, 1, 0, 0, 0, 0, 50);
    chk(n_cyc == 1 && g1[9], "R11 power-up over power-down", n_cyc, 1);

    // R9 power-down
    cmd(0, 0, 1, 0, 0, 0, 0, 50);
    chk(n_cyc == 2 && saw_done && !g1[9], "R9 reset cleared", g1, 32'h0000_0800);
    chk(!g1[31], "R12 lock drops", g1[31], 0);

    // R6 timeout on power-up
    lock_never = 1'b1;
    cmd(0, 1, 0, 0, 0, 0, 0, 400);
    chk(saw_err && !saw_done, "R6 err pulse", {saw_err, saw_done}, 2'b10);
    chk(n_cyc - t_rr >= TMO * CYC && n_cyc - t_rr <= TMO * CYC + 2, "R6 timeout length",
        n_cyc - t_rr, TMO * CYC);
    chk(g1[4] && g1[9] && !busy1, "R6 bypass held", g1, 32'h0000_0A10);
    lock_never = 1'b0;

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule